// File: doc/BRIEF.md
# Error Message Forwarding Gate

This block sits at one hop of an error-reporting path and decides whether an error message presented to it is passed further upstream. An error arrives as a one-cycle strobe carrying a severity. The block weighs that severity against the legacy system-error enable in the command register, the per-severity reporting enables in device control and, for bridge-type ports, the system-error enable in bridge control. One cycle later it presents its verdict: forward, drop, or, at a root port, hand the message to the root status collector. Alongside the verdict it emits set pulses for the signaled-system-error and received-system-error status bits. These pulses can fire even when the message is finally dropped.

A multi-hop path is built by chaining instances, with the forward output of one hop driving the strobe of the next. A hop whose function is not an express device stops the message and has no side effects.

Top module: `err_fwd_gate`

## Requirements
- R1: Severity is one-hot in 3 bits: bit 0 correctable, bit 1 non-fatal, bit 2 fatal. Any strobe whose severity is not exactly one-hot produces no output pulse at all. Non-fatal and fatal count as uncorrectable.
- R2: All outputs are registered. Each is a single-cycle pulse in the cycle after the strobe and is low in every other cycle, including after reset.
- R3: At a bridge-type port (port type 1 upstream, 2 downstream, 3 root), a valid uncorrectable message pulses `rcv_serr_set` whether or not the message is later dropped. At an endpoint (port type 0) or for a correctable message, `rcv_serr_set` stays low.
- R4: At a bridge-type port with the bridge SERR enable clear, the message is dropped and `sig_serr_set` stays low.
- R5: The first device gate passes when any of these holds: the message is uncorrectable and command SERR enable is set; it is non-fatal and the non-fatal reporting enable is set; it is correctable and the correctable reporting enable is set; it is fatal and the fatal reporting enable is set. Passing this gate pulses `sig_serr_set`.
- R6: A message that passes the first gate is delivered only if its own severity's enable is set in device control (bit 0 correctable, bit 1 non-fatal, bit 2 fatal). Command SERR enable alone does not deliver.
- R7: A delivered message at a root port pulses `to_root` and not `fwd`. At any other port type it pulses `fwd` and not `to_root`.
- R8: When `is_express` is low, nothing is pulsed for any message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_vld | input | 1 | Error message strobe |
| msg_sev | input | 3 | One-hot severity {fatal, non-fatal, correctable} |
| port_type | input | 2 | 0 endpoint, 1 upstream, 2 downstream, 3 root |
| is_express | input | 1 | Function is an express device |
| cmd_serr_en | input | 1 | Command register system-error enable |
| devctl_en | input | 3 | Reporting enables {fatal, non-fatal, correctable} |
| brctl_serr_en | input | 1 | Bridge control system-error enable |
| fwd | output | 1 | Forward the message to the next hop upstream |
| to_root | output | 1 | Deliver the message to the root status collector |
| sig_serr_set | output | 1 | Set pulse for signaled system error |
| rcv_serr_set | output | 1 | Set pulse for received system error |

## Verification
A wrong first-gate term or bridge gate shows up as a missing or extra `sig_serr_set` pulse, exactly one cycle after the offending strobe. A confusion between the two enable stages shows as a `sig_serr_set` pulse without a matching `fwd` or `to_root`, or the reverse. An error in the port-type decode either routes a delivered message to the wrong one of `fwd` and `to_root`, or drops the `rcv_serr_set` side effect. Since no state lives beyond one cycle, every fault is visible on the cycle after the strobe that exposes it.

// File: rtl/err_fwd_gate.sv
module err_fwd_gate #(
  parameter int SEV_W = 3,
  parameter int PT_W  = 2,
  parameter logic [PT_W-1:0] PT_ROOT = 2'd3,
  parameter logic [PT_W-1:0] PT_ENDP = 2'd0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_vld,
  input  logic [SEV_W-1:0] msg_sev,
  input  logic [PT_W-1:0]  port_type,
  input  logic             is_express,
  input  logic             cmd_serr_en,
  input  logic [SEV_W-1:0] devctl_en,
  input  logic             brctl_serr_en,
  output logic             fwd,
  output logic             to_root,
  output logic             sig_serr_set,
  output logic             rcv_serr_set
);
  localparam int COR = 0;

  logic sev_ok, uncor, bridge, live, br_pass, gate1, deliver;

  assign sev_ok  = (msg_sev != '0) && ((msg_sev & (msg_sev - 1'b1)) == '0);
  assign uncor   = !msg_sev[COR];
  assign bridge  = (port_type != PT_ENDP);
  assign live    = msg_vld && sev_ok && is_express;
  assign br_pass = !bridge || brctl_serr_en;
  assign gate1   = (uncor && cmd_serr_en) || ((msg_sev & devctl_en) != '0);
  assign deliver = live && br_pass && gate1 && ((msg_sev & devctl_en) != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd          <= 1'b0;
      to_root      <= 1'b0;
      sig_serr_set <= 1'b0;
      rcv_serr_set <= 1'b0;
    end else begin
      rcv_serr_set <= live && bridge && uncor;
      sig_serr_set <= live && br_pass && gate1;
      to_root      <= deliver && (port_type == PT_ROOT);
      fwd          <= deliver && (port_type != PT_ROOT);
    end
  end

  a_r7_exclusive_route: assert property (@(posedge clk) disable iff (!rst_n)
    !(fwd && to_root));
  a_r6_deliver_needs_signal: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd || to_root) |-> sig_serr_set);
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(msg_vld) |-> !(fwd || to_root || sig_serr_set || rcv_serr_set));
  a_r8_non_express_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_vld && !is_express) |=> !(fwd || to_root || sig_serr_set || rcv_serr_set));
  a_r4_bridge_block: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_vld && port_type != PT_ENDP && !brctl_serr_en) |=> !(sig_serr_set || fwd || to_root));
  a_r3_endpoint_no_rcv: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_vld && port_type == PT_ENDP) |=> !rcv_serr_set);
  a_r1_bad_sev_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_vld && !$onehot0(msg_sev)) |=> !(fwd || to_root || sig_serr_set || rcv_serr_set));
endmodule

// File: tb/sim_err_fwd_gate.sv
module sim_err_fwd_gate;
  logic clk = 0, rst_n = 0, msg_vld = 0, is_express = 1, cmd_serr_en = 0, brctl_serr_en = 0;
  logic [2:0] msg_sev = 0, devctl_en = 0;
  logic [1:0] port_type = 0;
  logic fwd, to_root, sig_serr_set, rcv_serr_set;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  err_fwd_gate u0 (.clk, .rst_n, .msg_vld, .msg_sev, .port_type, .is_express,
    .cmd_serr_en, .devctl_en, .brctl_serr_en, .fwd, .to_root, .sig_serr_set, .rcv_serr_set);

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got {fwd,root,sig,rcv}=%b expected %b", req, act, exp);
    end
  endtask

  // Returns outputs sampled in the cycle after the strobe, then one idle cycle.
  task automatic send(input logic [2:0] sev, input logic [1:0] pt, input logic ex,
                      input logic cse, input logic [2:0] dc, input logic bse,
                      output logic [3:0] res, output logic [3:0] idle);
    @(negedge clk);
    msg_vld = 1; msg_sev = sev; port_type = pt; is_express = ex;
    cmd_serr_en = cse; devctl_en = dc; brctl_serr_en = bse;
    @(negedge clk);
    msg_vld = 0;
    res = {fwd, to_root, sig_serr_set, rcv_serr_set};
    @(negedge clk);
    idle = {fwd, to_root, sig_serr_set, rcv_serr_set};
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R2 reset", {fwd, to_root, sig_serr_set, rcv_serr_set}, 4'b0000);
  endtask

  task automatic t_endpoint;
    logic [3:0] r, i;
    send(3'b001, 0, 1, 0, 3'b001, 0, r, i); chk("R5 cor endpoint fwd", r, 4'b1010);
    chk("R2 pulse ends", i, 4'b0000);
    send(3'b010, 0, 1, 1, 3'b000, 0, r, i); chk("R6 cmd serr only", r, 4'b0010);
    send(3'b001, 0, 1, 1, 3'b000, 0, r, i); chk("R5 cor ignores cmd serr", r, 4'b0000);
    send(3'b100, 0, 1, 0, 3'b100, 0, r, i); chk("R5 fatal enable", r, 4'b1010);
    send(3'b010, 0, 1, 0, 3'b101, 0, r, i); chk("R5 nonfatal mismatch", r, 4'b0000);
  endtask

  task automatic t_bridge;
    logic [3:0] r, i;
    send(3'b100, 1, 1, 1, 3'b100, 0, r, i); chk("R4 bridge blocked, R3 rcv", r, 4'b0001);
    send(3'b010, 2, 1, 0, 3'b010, 1, r, i); chk("R3 downstream nonfatal", r, 4'b1011);
    send(3'b001, 1, 1, 0, 3'b001, 1, r, i); chk("R3 cor no rcv", r, 4'b1010);
    send(3'b010, 2, 1, 0, 3'b000, 1, r, i); chk("R3 rcv when dropped", r, 4'b0001);
  endtask

  task automatic t_root;
    logic [3:0] r, i;
    send(3'b100, 3, 1, 0, 3'b100, 1, r, i); chk("R7 root fatal", r, 4'b0111);
    send(3'b001, 3, 1, 0, 3'b001, 1, r, i); chk("R7 root cor", r, 4'b0110);
  endtask

  task automatic t_misc;
    logic [3:0] r, i;
    send(3'b011, 0, 1, 1, 3'b111, 1, r, i); chk("R1 two-hot", r, 4'b0000);
    send(3'b000, 3, 1, 1, 3'b111, 1, r, i); chk("R1 zero sev", r, 4'b0000);
    send(3'b100, 3, 0, 1, 3'b111, 1, r, i); chk("R8 non-express", r, 4'b0000);
  endtask

  initial begin
    fork
      begin
        repeat (2) @(negedge clk);
        rst_n = 1;
        t_reset; t_endpoint; t_bridge; t_root; t_misc;
      end
      begin
        repeat (5000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule